// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

This block clears or paints a region of memory with a constant. A host sets up one of two fill channels through a small register write port. Each channel holds a start address, an end address, a fill constant and a control word. Setting the trigger bit in the control word starts the fill. The engine then walks the region one 32-bit word at a time on a single write master port, which uses a valid/ready handshake. At the end it updates the channel's status bits and may pulse that channel's interrupt line.

Each channel writes in one of two ways. In word mode it writes the whole 32-bit constant to every word. In packed mode it repeats the low three bytes of the constant as back-to-back 3-byte groups. A region whose end does not lie above its start is rejected without touching memory, but it still completes. When both channels are pending at once, channel 0 goes first.

Top module: `memfill_engine`

## Requirements
- R1: After reset both trigger bits, both finished bits, both interrupt lines and `mem_valid` are 0.
- R2: A register write stores `reg_wdata` into the field picked by `reg_field` for every channel whose bit is set in `reg_mask`. The field codes are 0 for start, 1 for end, 2 for the fill constant and 3 for control. Start and end fields count 8-byte units, so the byte address is the field times 8, and the end is exclusive. In the control word, bit 0 written as 1 sets the trigger, and bit 8 selects packed mode.
- R3: In word mode the engine writes every 32-bit word in [start, end) exactly once, in ascending address order, with the fill constant, and writes nothing outside that range. Byte lane j of `mem_data` goes to byte address `mem_addr`+j.
- R4: In packed mode, the byte at offset k from the start byte receives byte (k mod 3) of the fill constant, where byte 0 is bits 7:0.
- R5: If end is not greater than start, no memory write is issued and the operation still completes.
- R6: At completion of every triggered operation, the channel's trigger bit clears and its finished bit sets, in the same cycle.
- R7: Completion of channel i gives a one-cycle pulse on `irq[i]`, together with the finished bit, but only when the start field is nonzero.
- R8: When both channels are pending together, channel 0's operation runs and completes before channel 1's begins.
- R9: A control write with bit 1 set clears that channel's finished bit.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R11: Field writes made while a fill runs do not change that fill. The engine captures the range, the constant and the mode when the operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_mask | input | NUM_CH | Channels that take the write |
| reg_field | input | 2 | Field code of the write |
| reg_wdata | input | 32 | Write data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_data | output | 32 | Word to write |
| irq | output | NUM_CH | Per-channel completion pulse |
| trig_status | output | NUM_CH | Trigger bits |
| fin_status | output | NUM_CH | Finished bits |

## Verification
The bench tries every pairing of start fields 0 to 3 with end fields 0 to 5. This covers empty, reversed, zero-start and multi-word regions, in both write modes and on both channels, against a pseudo-random ready pattern. The empty and reversed pairs separate "rejected but completed" from "filled". A zero start separates a fill that raises an interrupt from one that does not. Lengths that are not multiples of three expose phase errors in packed mode. A simultaneous trigger of both channels checks the order of service. Rewriting the fields during a stalled fill checks that the engine captured its settings at the start.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_END   = 2'd1,
    FLD_VALUE = 2'd2,
    FLD_CTRL  = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  localparam int CTRL_TRIG_BIT = 0;
  localparam int CTRL_FIN_BIT  = 1;
  localparam int CTRL_MODE_BIT = 8;

  // Lane j of a packed word gets constant byte (phase + j) mod 3.
  function automatic logic [31:0] pack24(input logic [23:0] v, input logic [1:0] ph);
    logic [31:0] w;
    int k;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      k = (int'(ph) + j) % 3;
      w[j*8 +: 8] = v[k*8 +: 8];
    end
    return w;
  endfunction

endpackage

// File: rtl/memfill_chan_regs.sv
module memfill_chan_regs
  import memfill_pkg::*;
#(
  parameter int FW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  fld_e          wr_field,
  input  logic [31:0]   wr_data,
  input  logic          done_i,
  output logic [FW-1:0] start_o,
  output logic [FW-1:0] end_o,
  output logic [31:0]   value_o,
  output logic          mode24_o,
  output logic          trig_o,
  output logic          fin_o
);

  logic [FW-1:0] start_q, start_d, end_q, end_d;
  logic [31:0]   value_q, value_d;
  logic          mode_q, mode_d, trig_q, trig_d, fin_q, fin_d;
  logic          ctrl_wr;

  assign ctrl_wr = wr_en && (wr_field == FLD_CTRL);

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    value_d = value_q;
    mode_d  = mode_q;
    trig_d  = trig_q;
    fin_d   = fin_q;
    if (wr_en && wr_field == FLD_START) start_d = wr_data[FW-1:0];
    if (wr_en && wr_field == FLD_END)   end_d   = wr_data[FW-1:0];
    if (wr_en && wr_field == FLD_VALUE) value_d = wr_data;
    if (ctrl_wr) mode_d = wr_data[CTRL_MODE_BIT];
    if (done_i) trig_d = 1'b0;
    if (ctrl_wr && wr_data[CTRL_TRIG_BIT]) trig_d = 1'b1;
    if (ctrl_wr && wr_data[CTRL_FIN_BIT]) fin_d = 1'b0;
    if (done_i) fin_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      value_q <= '0;
      mode_q  <= 1'b0;
      trig_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      value_q <= value_d;
      mode_q  <= mode_d;
      trig_q  <= trig_d;
      fin_q   <= fin_d;
    end
  end

  assign start_o  = start_q;
  assign end_o    = end_q;
  assign value_o  = value_q;
  assign mode24_o = mode_q;
  assign trig_o   = trig_q;
  assign fin_o    = fin_q;

  // R6: completion always leaves the finished bit set
  a_r6_done_sets_fin: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> fin_q);

  // R6: completion without a fresh trigger write leaves the trigger clear
  a_r6_done_clears_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !(ctrl_wr && wr_data[CTRL_TRIG_BIT])) |=> !trig_q);

endmodule

// File: rtl/memfill_pick.sv
module memfill_pick #(
  parameter int NUM_CH = 2,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any_o,
  output logic [IW-1:0]     idx_o
);

  // Lowest index wins.
  always_comb begin
    any_o = |req;
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/memfill_core.sv
module memfill_core
  import memfill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 2,
  localparam int FW = ADDR_W - 3,
  localparam int WW = ADDR_W - 2,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_any,
  input  logic [IW-1:0]     pick_idx,
  input  logic [FW-1:0]     sel_start,
  input  logic [FW-1:0]     sel_end,
  input  logic [31:0]       sel_value,
  input  logic              sel_mode,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              done_o,
  output logic [IW-1:0]     done_idx,
  output logic              irq_fire
);

  st_e           st_q, st_d;
  logic [WW-1:0] cur_q, cur_d, end_q, end_d, cur_nxt;
  logic [31:0]   val_q, val_d;
  logic          mode_q, mode_d, zero_q, zero_d;
  logic [1:0]    ph_q, ph_d;
  logic [IW-1:0] ch_q, ch_d;

  assign cur_nxt = cur_q + WW'(1);

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    end_d  = end_q;
    val_d  = val_q;
    mode_d = mode_q;
    ph_d   = ph_q;
    zero_d = zero_q;
    ch_d   = ch_q;
    case (st_q)
      ST_IDLE: begin
        if (pick_any) begin
          ch_d   = pick_idx;
          cur_d  = {sel_start, 1'b0};
          end_d  = {sel_end, 1'b0};
          val_d  = sel_value;
          mode_d = sel_mode;
          ph_d   = 2'd0;
          zero_d = (sel_start == '0);
          st_d   = (sel_end > sel_start) ? ST_RUN : ST_DONE;
        end
      end
      ST_RUN: begin
        if (mem_ready) begin
          cur_d = cur_nxt;
          ph_d  = (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
          if (cur_nxt == end_q) st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      end_q  <= '0;
      val_q  <= '0;
      mode_q <= 1'b0;
      ph_q   <= 2'd0;
      zero_q <= 1'b0;
      ch_q   <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      end_q  <= end_d;
      val_q  <= val_d;
      mode_q <= mode_d;
      ph_q   <= ph_d;
      zero_q <= zero_d;
      ch_q   <= ch_d;
    end
  end

  assign mem_valid = (st_q == ST_RUN);
  assign mem_addr  = {cur_q, 2'b00};
  assign mem_data  = mode_q ? pack24(val_q[23:0], ph_q) : val_q;
  assign done_o    = (st_q == ST_DONE);
  assign done_idx  = ch_q;
  assign irq_fire  = done_o && !zero_q;

  // R10: a stalled request is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R3: every issued word lies below the captured end
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (cur_q < end_q));

  // R5: a rejected range goes straight to completion without a request
  a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pick_any && !(sel_end > sel_start)) |=> (!mem_valid && done_o));

endmodule

// File: rtl/memfill_engine.sv
module memfill_engine
  import memfill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 2,
  localparam int FW = ADDR_W - 3,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [NUM_CH-1:0] reg_mask,
  input  logic [1:0]        reg_field,
  input  logic [31:0]       reg_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] trig_status,
  output logic [NUM_CH-1:0] fin_status
);

  logic [FW-1:0] start_a [NUM_CH];
  logic [FW-1:0] end_a   [NUM_CH];
  logic [31:0]   value_a [NUM_CH];
  logic [NUM_CH-1:0] mode_a;
  logic          pick_any, core_done, irq_fire;
  logic [IW-1:0] pick_idx, done_idx;
  logic [NUM_CH-1:0] irq_q, irq_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    memfill_chan_regs #(.FW(FW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr && reg_mask[i]),
      .wr_field (fld_e'(reg_field)),
      .wr_data  (reg_wdata),
      .done_i   (core_done && (done_idx == IW'(i))),
      .start_o  (start_a[i]),
      .end_o    (end_a[i]),
      .value_o  (value_a[i]),
      .mode24_o (mode_a[i]),
      .trig_o   (trig_status[i]),
      .fin_o    (fin_status[i])
    );
    assign irq_d[i] = irq_fire && (done_idx == IW'(i));
  end

  memfill_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req   (trig_status),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  memfill_core #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_any  (pick_any),
    .pick_idx  (pick_idx),
    .sel_start (start_a[pick_idx]),
    .sel_end   (end_a[pick_idx]),
    .sel_value (value_a[pick_idx]),
    .sel_mode  (mode_a[pick_idx]),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .done_o    (core_done),
    .done_idx  (done_idx),
    .irq_fire  (irq_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R7: at most one line fires, and only for a single cycle
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |=> (irq == '0));
  // R7: an interrupt comes with the finished bit of its channel
  a_r7_with_fin: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~fin_status) == '0));

endmodule

// File: tb/memfill_engine_test.sv
`timescale 1ns/1ps
module memfill_engine_test;

  localparam int AW = 10;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_mask;
  logic [1:0]  reg_field;
  logic [31:0] reg_wdata;
  logic        mem_valid, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;
  logic [1:0]  irq, trig_status, fin_status;

  memfill_engine #(.ADDR_W(AW), .NUM_CH(2)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_mask(reg_mask),
    .reg_field(reg_field), .reg_wdata(reg_wdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq), .trig_status(trig_status), .fin_status(fin_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [0:(1<<AW)-1];
  int wr_cnt, irq0_cnt, irq1_cnt, cyc, t0, t1;
  logic [AW-1:0] first_addr;
  logic [15:0] lfsr;
  logic ready_en;

  assign mem_ready = ready_en & lfsr[0];

  always @(negedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && mem_valid && mem_ready) begin
      if (wr_cnt == 0) first_addr = mem_addr;
      for (int j = 0; j < 4; j++) mem[int'(mem_addr) + j] = mem_data[j*8 +: 8];
      wr_cnt++;
    end
    if (irq[0]) begin irq0_cnt++; if (t0 < 0) t0 = cyc; end
    if (irq[1]) begin irq1_cnt++; if (t1 < 0) t1 = cyc; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] m, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_mask = m; reg_field = f; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_mask = 2'b00;
  endtask

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 7) ^ 8'h3C);
  endfunction

  function automatic logic [7:0] exp_byte(input int a, input int s, input int e,
                                          input logic [31:0] v, input bit m);
    int k;
    if (e > s && a >= s*8 && a < e*8) begin
      k = a - s*8;
      return m ? v[(k % 3)*8 +: 8] : v[(k % 4)*8 +: 8];
    end
    return init_byte(a);
  endfunction

  task automatic clear_mem();
    for (int a = 0; a < 64; a++) mem[a] = init_byte(a);
    wr_cnt = 0; irq0_cnt = 0; irq1_cnt = 0; t0 = -1; t1 = -1;
  endtask

  task automatic wait_fin(input int ch);
    int n;
    n = 0;
    while (!fin_status[ch] && n < 3000) begin @(negedge clk); n++; end
    chk(fin_status[ch] == 1'b1, "R6", "finished bit seen", int'(fin_status[ch]), 1);
    repeat (2) @(negedge clk);
  endtask

  // Byte-exact comparison of addresses 0..63 against two regions.
  task automatic check_mem(input string req, input int s0, input int e0, input logic [31:0] v0,
                           input bit m0, input int s1, input int e1, input logic [31:0] v1, input bit m1);
    int bad, ba, bact, bexp;
    logic [7:0] x;
    bad = 0; ba = 0; bact = 0; bexp = 0;
    for (int a = 0; a < 64; a++) begin
      x = exp_byte(a, s0, e0, v0, m0);
      if (e1 > s1 && a >= s1*8 && a < e1*8) x = exp_byte(a, s1, e1, v1, m1);
      if (mem[a] !== x) begin
        if (bad == 0) begin ba = a; bact = int'(mem[a]); bexp = int'(x); end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s memory byte %0d: actual %0d expected %0d", req, ba, bact, bexp);
    end
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_mask = 2'b00; reg_field = 2'd0; reg_wdata = '0;
    ready_en = 1'b1; cyc = 0; t0 = -1; t1 = -1;
    wr_cnt = 0; irq0_cnt = 0; irq1_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(trig_status == 2'b00, "R1", "trigger bits", int'(trig_status), 0);
    chk(fin_status == 2'b00, "R1", "finished bits", int'(fin_status), 0);
    chk(irq == 2'b00, "R1", "irq", int'(irq), 0);
    chk(mem_valid == 1'b0, "R1", "mem_valid", int'(mem_valid), 0);

    // Sweep: R2 R3 R4 R5 R6 R7 R9
    for (int ch = 0; ch < 2; ch++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          for (int e = 0; e < 6; e++) begin
            logic [31:0] v;
            logic [1:0] msk;
            int exp_w, exp_i;
            v = 32'h11223344 + 32'(ch * 32'h01010101) + 32'(s * 16 + e);
            msk = 2'(1 << ch);
            clear_mem();
            reg_write(msk, 2'd0, 32'(s));
            reg_write(msk, 2'd1, 32'(e));
            reg_write(msk, 2'd2, v);
            reg_write(msk, 2'd3, 32'h1 | (32'(m) << 8));
            wait_fin(ch);
            exp_w = (e > s) ? (e - s) * 2 : 0;
            exp_i = (s != 0) ? 1 : 0;
            chk(trig_status[ch] == 1'b0, "R6", "trigger cleared", int'(trig_status[ch]), 0);
            chk(wr_cnt == exp_w, (e > s) ? "R3" : "R5", "write count", wr_cnt, exp_w);
            chk((ch == 0 ? irq0_cnt : irq1_cnt) == exp_i, "R7", "own irq pulses",
                ch == 0 ? irq0_cnt : irq1_cnt, exp_i);
            chk((ch == 0 ? irq1_cnt : irq0_cnt) == 0, "R7", "other irq pulses",
                ch == 0 ? irq1_cnt : irq0_cnt, 0);
            check_mem(m ? "R4" : "R3", s, e, v, m[0], 0, 0, 0, 1'b0);
            reg_write(msk, 2'd3, 32'h2);
            @(negedge clk);
            chk(fin_status[ch] == 1'b0, "R9", "finished cleared", int'(fin_status[ch]), 0);
          end
        end
      end
    end

    // R8: both channels triggered in one write
    clear_mem();
    reg_write(2'b01, 2'd0, 32'd1);
    reg_write(2'b01, 2'd1, 32'd3);
    reg_write(2'b01, 2'd2, 32'hA1B2C3D4);
    reg_write(2'b10, 2'd0, 32'd4);
    reg_write(2'b10, 2'd1, 32'd6);
    reg_write(2'b10, 2'd2, 32'h0F1E2D3C);
    reg_write(2'b11, 2'd3, 32'h1);
    wait_fin(0);
    wait_fin(1);
    chk(int'(first_addr) == 8, "R8", "first write address", int'(first_addr), 8);
    chk(t0 >= 0 && t1 > t0, "R8", "irq0 before irq1 (t1-t0)", t1 - t0, 1);
    check_mem("R8", 1, 3, 32'hA1B2C3D4, 1'b0, 4, 6, 32'h0F1E2D3C, 1'b0);
    reg_write(2'b11, 2'd3, 32'h2);

    // R11: fields rewritten during a stalled fill
    clear_mem();
    ready_en = 1'b0;
    reg_write(2'b01, 2'd0, 32'd1);
    reg_write(2'b01, 2'd1, 32'd6);
    reg_write(2'b01, 2'd2, 32'h00C0FFEE);
    reg_write(2'b01, 2'd3, 32'h101);
    reg_write(2'b01, 2'd2, 32'h55555555);
    reg_write(2'b01, 2'd1, 32'd2);
    reg_write(2'b01, 2'd0, 32'd0);
    chk(mem_valid == 1'b1, "R10", "request pending while stalled", int'(mem_valid), 1);
    chk(int'(mem_addr) == 8, "R10", "stalled address", int'(mem_addr), 8);
    ready_en = 1'b1;
    wait_fin(0);
    chk(wr_cnt == 10, "R11", "write count", wr_cnt, 10);
    chk(irq0_cnt == 1, "R11", "irq from captured start", irq0_cnt, 1);
    check_mem("R11", 1, 6, 32'h00C0FFEE, 1'b1, 0, 0, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule